// File: doc/BRIEF.md
# Frame CRC Check and Commit Buffer

This block sits behind a line decoder that has already located the start-of-frame delimiter. It accepts frame bytes one per clock, stores each byte in a buffer RAM, and folds the same byte into a running CRC-32 in the same cycle. The CRC logic works on all eight bits at once, so reception never stalls. When the last byte of a frame arrives, the block checks the CRC result. A frame that passes is released to the read side as one unit. A frame that fails is removed from the buffer as if it had never been written.

The buffer keeps a published write pointer that marks where the last good frame ends. Reads only ever see bytes below that pointer. A drop rewinds the private write pointer to the published one, so frames committed earlier, and still waiting to be read, are not touched. Short frames and frames that do not fit in the free space are dropped and flagged as errors. A status pulse reports every frame outcome.

Top module: `eth_fcs_gate`

## Requirements
- R1: After reset, `rd_empty` is 1, and `rd_vld`, `st_pulse`, `st_good` and `st_err` are 0.
- R2: A frame is a run of bytes with `in_valid` high. It starts at a byte with `in_sof` and ends at a byte with `in_eof`. Its last four bytes are the one's complement of the CRC-32 of the preceding bytes, sent least-significant byte first. The CRC uses the reflected polynomial 0xEDB88320, a preset of all ones, and bits taken LSB first. Such a frame is reported good: `st_good`=1, `st_err`=0.
- R3: `st_pulse` is high for exactly the one cycle after the clock edge that takes the end byte, and is low at all other times.
- R4: Each read is a cycle with `rd_en` high while `rd_empty` is 0. The next byte appears on `rd_data` in the following cycle, with `rd_vld`=1. A good frame reads back in arrival order, including its four check bytes, and `rd_empty` returns to 1 once the last byte has been read.
- R5: A frame whose check bytes do not match is reported with `st_good`=0 and `st_err`=0. None of its bytes ever reach the read side.
- R6: A dropped frame leaves earlier committed, unread frames intact and in order. Frames received after it are committed normally.
- R7: A frame with fewer than 4 bytes is dropped and reported with `st_err`=1 and `st_good`=0. A 4-byte frame with no payload and correct check bytes is good.
- R8: A frame that does not fit in the free buffer space is dropped with `st_err`=1, and earlier committed data is unaffected.
- R9: Bytes with `in_valid` high outside a frame (no `in_sof` and no frame open) are ignored and produce no status.
- R10: An `in_sof` while a frame is open abandons the open frame with no status. The new frame is handled normally.
- R11: Cycles with `in_valid` low inside a frame do not affect the frame or its check.
- R12: Bytes of a frame being received are not visible on the read side before the frame is committed.
- R13: Pointers wrap around the buffer, so frames keep passing correctly after more than one buffer's worth of data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Received frame byte |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| rd_en | input | 1 | Read request for the next committed byte |
| rd_data | output | 8 | Byte read from the buffer |
| rd_vld | output | 1 | `rd_data` is valid this cycle |
| rd_empty | output | 1 | No committed byte is waiting |
| st_pulse | output | 1 | Frame outcome is valid this cycle |
| st_good | output | 1 | Frame passed and was committed |
| st_err | output | 1 | Frame was dropped as too short or overflowing |

## Verification
The bench builds the block with `ADDR_W` = 5, a 32-byte buffer. With that size, a frame of about two dozen bytes overflows the buffer while an earlier frame is still unread. A few short frames are enough to wrap the pointers several times. The zero-payload four-byte frame and the three-byte runt test both sides of the length limit. Partial frames interrupted by a new start, and frames with idle gaps, exercise the restart and stall paths.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam logic [31:0] CRC_POLY_REFL    = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET       = 32'hFFFFFFFF;
  // value left in the reflected register after data plus a correct check field
  localparam logic [31:0] CRC_GOOD_RESIDUE = 32'hDEBB20E3;
  localparam int          MIN_FRAME_BYTES  = 4;

  // fold one byte into the reflected CRC register (eight shifts unrolled)
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) begin
      r = (r >> 1) ^ (CRC_POLY_REFL & {32{r[0]}});
    end
    return r;
  endfunction
endpackage

// File: rtl/fcs_crc_acc.sv
module fcs_crc_acc
  import fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [31:0] crc_next
);
  logic [31:0] crc_q;

  // a frame start discards the old state and folds the byte into the preset
  assign crc_next = crc_step_byte(first ? CRC_PRESET : crc_q, data);

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= CRC_PRESET;
    else if (en) crc_q <= crc_next;
  end
endmodule

// File: rtl/fcs_frame_buf.sv
module fcs_frame_buf #(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_req,
  input  logic       wr_first,
  input  logic [7:0] wr_data,
  input  logic       fin_commit,
  input  logic       fin_drop,
  output logic       wr_full,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_vld,
  output logic       rd_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr, pub_ptr, rd_ptr;
  logic [PW-1:0] wa, wa_after, used;
  logic          wr_ok, rd_fire;

  // a new frame always starts at the published pointer, so an open frame is abandoned
  assign wa       = wr_first ? pub_ptr : wr_ptr;
  assign used     = wa - rd_ptr;
  assign wr_full  = (used == PW'(DEPTH));
  assign wr_ok    = wr_req && !wr_full;
  assign wa_after = wr_ok ? wa + PW'(1) : wa;
  assign rd_empty = (rd_ptr == pub_ptr);
  assign rd_fire  = rd_en && !rd_empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wa[ADDR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_data <= mem[rd_ptr[ADDR_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      pub_ptr <= '0;
      rd_ptr  <= '0;
      rd_vld  <= 1'b0;
    end else begin
      if (fin_drop)    wr_ptr <= pub_ptr;
      else if (wr_req) wr_ptr <= wa_after;
      if (fin_commit)  pub_ptr <= wa_after;
      if (rd_fire)     rd_ptr <= rd_ptr + PW'(1);
      rd_vld <= rd_fire;
    end
  end
endmodule

// File: rtl/fcs_frame_ctl.sv
module fcs_frame_ctl
  import fcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic [31:0] crc_next,
  input  logic        buf_full,
  output logic        acc,
  output logic        first,
  output logic        commit,
  output logic        drop,
  output logic        st_pulse,
  output logic        st_good,
  output logic        st_err
);
  localparam int CW = $clog2(MIN_FRAME_BYTES + 1);

  logic          in_frame, ovf_q, ovf_now, fin, crc_ok, long_enough;
  logic [CW-1:0] cnt_q, cnt_now;

  assign first       = in_valid && in_sof;
  assign acc         = in_valid && (in_sof || in_frame);
  assign cnt_now     = first ? CW'(1)
                     : ((cnt_q == CW'(MIN_FRAME_BYTES)) ? cnt_q : cnt_q + CW'(1));
  assign ovf_now     = (first ? 1'b0 : ovf_q) | buf_full;
  assign fin         = acc && in_eof;
  assign crc_ok      = (crc_next == CRC_GOOD_RESIDUE);
  assign long_enough = (cnt_now == CW'(MIN_FRAME_BYTES));
  assign commit      = fin && !ovf_now && long_enough && crc_ok;
  assign drop        = fin && !commit;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      ovf_q    <= 1'b0;
      cnt_q    <= '0;
      st_pulse <= 1'b0;
      st_good  <= 1'b0;
      st_err   <= 1'b0;
    end else begin
      if (acc) begin
        in_frame <= !in_eof;
        ovf_q    <= ovf_now;
        cnt_q    <= cnt_now;
      end
      st_pulse <= fin;
      st_good  <= commit;
      st_err   <= fin && (ovf_now || !long_enough);
    end
  end
endmodule

// File: rtl/eth_fcs_gate.sv
module eth_fcs_gate #(
  parameter int ADDR_W = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_vld,
  output logic       rd_empty,
  output logic       st_pulse,
  output logic       st_good,
  output logic       st_err
);
  logic [31:0] crc_next;
  logic        acc, first, commit, drop, buf_full;

  fcs_crc_acc u_crc (
    .clk(clk), .rst(rst), .en(acc), .first(first), .data(in_data), .crc_next(crc_next)
  );

  fcs_frame_ctl u_ctl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .crc_next(crc_next), .buf_full(buf_full), .acc(acc), .first(first),
    .commit(commit), .drop(drop), .st_pulse(st_pulse), .st_good(st_good), .st_err(st_err)
  );

  fcs_frame_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst(rst), .wr_req(acc), .wr_first(first), .wr_data(in_data),
    .fin_commit(commit), .fin_drop(drop), .wr_full(buf_full),
    .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld), .rd_empty(rd_empty)
  );
endmodule

// File: rtl/eth_fcs_gate_chk.sv
module eth_fcs_gate_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_eof,
  input logic       rd_en,
  input logic       rd_vld,
  input logic       rd_empty,
  input logic       st_pulse,
  input logic       st_good,
  input logic       st_err
);
  // R2
  good_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    st_good |-> st_pulse);

  // R7
  err_not_good_chk: assert property (@(posedge clk) disable iff (rst)
    st_err |-> (st_pulse && !st_good));

  // R3
  pulse_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    st_pulse |-> $past(in_valid && in_eof));

  // R12
  visible_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_empty) |-> st_good);

  // R4
  read_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> $past(rd_en && !rd_empty));
endmodule

bind eth_fcs_gate eth_fcs_gate_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof), .rd_en(rd_en),
  .rd_vld(rd_vld), .rd_empty(rd_empty), .st_pulse(st_pulse), .st_good(st_good),
  .st_err(st_err)
);

// File: tb/eth_fcs_gate_bench.sv
module eth_fcs_gate_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_vld, rd_empty, st_pulse, st_good, st_err;

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;
  logic [7:0] fr [0:63];
  logic [7:0] exp_q [$];

  always #4 clk = ~clk; // 125 MHz

  eth_fcs_gate #(.ADDR_W(5)) u_eth_fcs_gate (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .rd_en(rd_en), .rd_data(rd_data), .rd_vld(rd_vld),
    .rd_empty(rd_empty), .st_pulse(st_pulse), .st_good(st_good), .st_err(st_err)
  );

  task automatic finish_up();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<50000 cycles", cyc);
      finish_up();
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // serial bit-at-a-time reference CRC over fr[0..n-1]
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ fr[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return c;
  endfunction

  // payload of np bytes plus four check bytes; returns total length
  function automatic int build(input int np, input int seed);
    logic [31:0] f;
    for (int i = 0; i < np; i++) fr[i] = 8'(seed + i * 7);
    f = ~ref_crc(np);
    for (int k = 0; k < 4; k++) fr[np + k] = f[8*k +: 8];
    return np + 4;
  endfunction

  // drive fr[0..n-1]; then check the status pulse and its one-cycle width
  task automatic send(input int n, input bit gaps, input bit exp_good, input bit exp_err,
                      input string req, input bit chk_hidden);
    for (int i = 0; i < n; i++) begin
      if (gaps && i % 2 == 1) begin
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
      end
      @(negedge clk);
      if (i == n - 1 && chk_hidden)
        check(rd_empty == 1, {req, " R12 hidden before commit"}, rd_empty, 1);
      in_valid = 1; in_data = fr[i]; in_sof = (i == 0); in_eof = (i == n - 1);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;
    check(st_pulse == 1, {req, " R3 pulse"}, st_pulse, 1);
    check(st_good == exp_good, {req, " good"}, st_good, exp_good);
    check(st_err == exp_err, {req, " err"}, st_err, exp_err);
    @(negedge clk);
    check(st_pulse == 0, {req, " R3 pulse width"}, st_pulse, 0);
    if (exp_good) for (int i = 0; i < n; i++) exp_q.push_back(fr[i]);
  endtask

  task automatic read_expect(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      check(rd_empty == 0, {req, " R4 not empty"}, rd_empty, 0);
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
      check(rd_vld == 1 && rd_data == e, {req, " R4 data"}, rd_data, e);
    end
    @(negedge clk);
    check(rd_empty == 1, {req, " R4 empty after"}, rd_empty, 1);
  endtask

  task automatic t_reset();
    check(rd_empty == 1 && rd_vld == 0, "R1 read side", {rd_empty, rd_vld}, 2);
    check(st_pulse == 0 && st_good == 0 && st_err == 0, "R1 status",
          {st_pulse, st_good, st_err}, 0);
  endtask

  task automatic t_good();
    int n;
    n = build(10, 3);
    send(n, 0, 1, 0, "R2 good", 1);
    read_expect(n, "R2");
  endtask

  task automatic t_bad();
    int n;
    n = build(9, 40);
    fr[2] ^= 8'h01;
    send(n, 0, 0, 0, "R5 bad", 0);
    @(negedge clk);
    check(rd_empty == 1, "R5 nothing visible", rd_empty, 1);
  endtask

  task automatic t_mixed();
    int n1, n2, n3;
    n1 = build(4, 11); send(n1, 0, 1, 0, "R6 first", 0);
    n2 = build(5, 90); fr[n2 - 1] ^= 8'h80; send(n2, 0, 0, 0, "R6 bad", 0);
    n3 = build(3, 60); send(n3, 0, 1, 0, "R6 third", 0);
    read_expect(n1 + n3, "R6");
  endtask

  task automatic t_runt();
    fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33;
    send(3, 0, 0, 1, "R7 runt", 0);
    @(negedge clk);
    check(rd_empty == 1, "R7 runt dropped", rd_empty, 1);
    begin
      int n;
      n = build(0, 0);
      send(n, 0, 1, 0, "R7 four-byte", 0);
      read_expect(n, "R7");
    end
  endtask

  task automatic t_overflow();
    int n1, n2;
    n1 = build(10, 5); send(n1, 0, 1, 0, "R8 keep", 0);
    n2 = build(20, 77); send(n2, 0, 0, 1, "R8 overflow", 0);
    read_expect(n1, "R8");
  endtask

  task automatic t_stray();
    int n;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'hA0 + 8'(i); in_eof = (i == 2);
    end
    @(negedge clk); in_valid = 0; in_eof = 0;
    check(st_pulse == 0, "R9 no status", st_pulse, 0);
    @(negedge clk);
    check(rd_empty == 1, "R9 ignored", rd_empty, 1);
    n = build(6, 21); send(n, 0, 1, 0, "R9 after", 0);
    read_expect(n, "R9");
  endtask

  task automatic t_restart();
    int n;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); in_valid = 1; in_data = 8'h50 + 8'(i); in_sof = (i == 0);
    end
    @(negedge clk); in_valid = 0; in_sof = 0;
    check(st_pulse == 0, "R10 no status", st_pulse, 0);
    n = build(7, 33); send(n, 0, 1, 0, "R10 new", 0);
    read_expect(n, "R10");
  endtask

  task automatic t_gaps();
    int n;
    n = build(8, 19); send(n, 1, 1, 0, "R11 gaps", 0);
    read_expect(n, "R11");
  endtask

  task automatic t_wrap();
    for (int r = 0; r < 4; r++) begin
      int n;
      n = build(12, 100 + r);
      send(n, 0, 1, 0, "R13 wrap", 0);
      read_expect(n, "R13");
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_good();
    t_bad();
    t_mixed();
    t_runt();
    t_overflow();
    t_stray();
    t_restart();
    t_gaps();
    t_wrap();
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule